// File: doc/BRIEF.md
# Indexed Real-Time Clock Register Port

This block is a small real-time clock whose registers are reached through two byte-wide ports: an index port and a data port. Software first writes a register index to the index port and then reads the data port. Each read returns either a control register or a calendar field for the selected index. The block counts seconds, minutes, hours, day of week, day of month, month and year in plain binary and advances them once per second. A second divider issues a periodic interrupt pulse at a fixed rate.

Control register A returns a fixed rate pattern. Its top bit is an update-in-progress flag that flips on every read of A. Control register B returns a fixed mode byte. Control register C reads as zero. Any access the block does not support produces a one-cycle error pulse. Unsupported accesses are data-port writes, reads of register D, reads of an unknown index and reads of the index port. The starting date and time come from preset inputs, which are loaded while reset is held.

Top module: `rtc_index_port`

## Requirements
- R1: A write with `portSel`=0 latches `wrData` as the register index. A read with `portSel`=1 returns the addressed register on `rdData` in the cycle after the read strobe, with `rdValid` high for that one cycle. `rdData` holds its value when no read is made. After reset `rdData`, `rdValid`, `errPulse` and `periodicIrq` are 0.
- R2: Index 0x0A returns 0x26 with bit 7 replaced by the update-in-progress flag. The flag is 1 after reset and inverts after each read of index 0x0A and after no other access, so the first three reads after reset give 0xA6, 0x26 and 0xA6.
- R3: Index 0x0B reads as the constant 0x46 and index 0x0C reads as 0x00, with no error.
- R4: A data-port read of index 0x0D or of any index outside 0x00, 0x02, 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0B and 0x0C returns 0x00 with `rdValid` high and `errPulse` high in the following cycle. A read with `portSel`=0 raises `errPulse` and leaves `rdValid` low.
- R5: A write with `portSel`=1 raises `errPulse` in the following cycle and changes neither the index nor any register.
- R6: Field indices: 0x00 seconds (0-59), 0x02 minutes (0-59), 0x04 hours (0-23), 0x06 day of week (0-6), 0x07 day of month (1-31), 0x08 month, read as the zero-based month plus 1, and 0x09 year. The year is held as years since 1900 and read as that count minus 52, modulo 256.
- R7: While `rstN` is low, the calendar loads `presetSec`, `presetMin`, `presetHour`, `presetWday`, `presetMday`, `presetMon` (zero-based) and `presetYear` (years since 1900).
- R8: The seconds field advances once every TICKS_PER_SEC clock cycles. Seconds, minutes and hours roll over into the next field, and the day of week wraps from 6 to 0 at midnight.
- R9: At midnight the day of month rolls to 1 after the last day of the month: 30 for April, June, September and November, and 31 for the other months except February. February has 29 days when the full year is divisible by 4 and is not a century year unless it is divisible by 400, and 28 days otherwise. December rolls to January of the next year.
- R10: `periodicIrq` is a one-cycle pulse repeating every TICKS_PER_SEC/PERIODIC_RATE cycles, which is 1024 pulses per second at the default rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; also loads the presets |
| rdEn | input | 1 | Read strobe, one cycle per access |
| wrEn | input | 1 | Write strobe, one cycle per access |
| portSel | input | 1 | 0 selects the index port, 1 selects the data port |
| wrData | input | 8 | Write data |
| presetSec | input | 8 | Initial seconds |
| presetMin | input | 8 | Initial minutes |
| presetHour | input | 8 | Initial hours |
| presetWday | input | 8 | Initial day of week, 0-6 |
| presetMday | input | 8 | Initial day of month, 1-31 |
| presetMon | input | 8 | Initial month, 0-11 |
| presetYear | input | 8 | Initial year, years since 1900 |
| rdData | output | 8 | Read data, registered |
| rdValid | output | 1 | Read data valid for one cycle |
| errPulse | output | 1 | One-cycle pulse for an unsupported access |
| periodicIrq | output | 1 | Periodic interrupt pulse |

## Verification
The bench builds the block with TICKS_PER_SEC=64 and PERIODIC_RATE=16. A simulated second is then 64 cycles and the periodic pulse repeats every 4 cycles. With those values, a few seconds of run time carry the presets across a minute, an hour, a day, a month and a year boundary. The bench loads presets just before midnight on 28 February of 2000, 2001 and 2100, on 30 April and on 31 December, which exercises every branch of the days-per-month and leap-year rules.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] IDX_SEC  = 8'h00;
  localparam logic [7:0] IDX_MIN  = 8'h02;
  localparam logic [7:0] IDX_HOUR = 8'h04;
  localparam logic [7:0] IDX_WDAY = 8'h06;
  localparam logic [7:0] IDX_MDAY = 8'h07;
  localparam logic [7:0] IDX_MON  = 8'h08;
  localparam logic [7:0] IDX_YEAR = 8'h09;
  localparam logic [7:0] IDX_CTLA = 8'h0A;
  localparam logic [7:0] IDX_CTLB = 8'h0B;
  localparam logic [7:0] IDX_CTLC = 8'h0C;

  localparam logic [6:0] CTLA_RATE  = 7'h26;
  localparam logic [7:0] CTLB_VALUE = 8'h46;
  localparam logic [7:0] MONTH_BIAS = 8'd1;
  localparam logic [7:0] YEAR_BIAS  = 8'd52;
  localparam logic [11:0] BASE_YEAR = 12'd1900;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_CTLA, SRC_CTLB, SRC_SEC, SRC_MIN, SRC_HOUR,
    SRC_WDAY, SRC_MDAY, SRC_MON, SRC_YEAR
  } rd_src_e;

  typedef struct packed {
    logic    load;
    rd_src_e src;
    logic    uip;
  } ctl_strobe_t;

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        portSel,
  input  logic [7:0]  wrData,
  output ctl_strobe_t strobe,
  output logic        errPulse
);

  logic [7:0] indexReg;
  logic       uipFlag;
  rd_src_e    srcSel;
  logic       idxBad;
  logic       dataRead;
  logic       errNext;

  always_comb begin
    idxBad = 1'b0;
    case (indexReg)
      IDX_SEC:  srcSel = SRC_SEC;
      IDX_MIN:  srcSel = SRC_MIN;
      IDX_HOUR: srcSel = SRC_HOUR;
      IDX_WDAY: srcSel = SRC_WDAY;
      IDX_MDAY: srcSel = SRC_MDAY;
      IDX_MON:  srcSel = SRC_MON;
      IDX_YEAR: srcSel = SRC_YEAR;
      IDX_CTLA: srcSel = SRC_CTLA;
      IDX_CTLB: srcSel = SRC_CTLB;
      IDX_CTLC: srcSel = SRC_ZERO;
      default: begin
        srcSel = SRC_ZERO;
        idxBad = 1'b1;
      end
    endcase
  end

  assign dataRead    = rdEn && portSel;
  assign errNext     = (rdEn && !portSel) || (wrEn && portSel) || (dataRead && idxBad);
  assign strobe.load = dataRead;
  assign strobe.src  = srcSel;
  assign strobe.uip  = uipFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= 8'h00;
      uipFlag  <= 1'b1;
      errPulse <= 1'b0;
    end else begin
      if (wrEn && !portSel) indexReg <= wrData;
      if (dataRead && srcSel == SRC_CTLA) uipFlag <= ~uipFlag;
      errPulse <= errNext;
    end
  end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int PERIODIC_RATE = 1024
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobe,
  input  logic [7:0]  presetSec,
  input  logic [7:0]  presetMin,
  input  logic [7:0]  presetHour,
  input  logic [7:0]  presetWday,
  input  logic [7:0]  presetMday,
  input  logic [7:0]  presetMon,
  input  logic [7:0]  presetYear,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        periodicIrq
);

  localparam int PER_DIV = TICKS_PER_SEC / PERIODIC_RATE;
  localparam int SEC_W   = $clog2(TICKS_PER_SEC);
  localparam int PER_W   = $clog2(PER_DIV);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(TICKS_PER_SEC - 1);
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(PER_DIV - 1);

  logic [SEC_W-1:0] secDiv;
  logic [PER_W-1:0] perDiv;
  logic             secTick;

  logic [7:0] sec, min, hour, wday, mday, mon, year;
  logic [7:0] nSec, nMin, nHour, nWday, nMday, nMon, nYear;
  logic [7:0] monthDays;
  logic [7:0] muxData;

  function automatic logic isLeap(input logic [7:0] yr);
    logic [11:0] full;
    full = BASE_YEAR + {4'd0, yr};
    return (full[1:0] == 2'b00) &&
           (((full % 12'd100) != 12'd0) || ((full % 12'd400) == 12'd0));
  endfunction

  always_comb begin
    case (mon)
      8'd1:                      monthDays = isLeap(year) ? 8'd29 : 8'd28;
      8'd3, 8'd5, 8'd8, 8'd10:   monthDays = 8'd30;
      default:                   monthDays = 8'd31;
    endcase
  end

  assign secTick = (secDiv == SEC_LAST);

  always_comb begin
    nSec = sec; nMin = min; nHour = hour; nWday = wday;
    nMday = mday; nMon = mon; nYear = year;
    if (secTick) begin
      if (sec != 8'd59) nSec = sec + 8'd1;
      else begin
        nSec = 8'd0;
        if (min != 8'd59) nMin = min + 8'd1;
        else begin
          nMin = 8'd0;
          if (hour != 8'd23) nHour = hour + 8'd1;
          else begin
            nHour = 8'd0;
            nWday = (wday == 8'd6) ? 8'd0 : wday + 8'd1;
            if (mday != monthDays) nMday = mday + 8'd1;
            else begin
              nMday = 8'd1;
              if (mon != 8'd11) nMon = mon + 8'd1;
              else begin
                nMon  = 8'd0;
                nYear = year + 8'd1;
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    case (strobe.src)
      SRC_CTLA: muxData = {strobe.uip, CTLA_RATE};
      SRC_CTLB: muxData = CTLB_VALUE;
      SRC_SEC:  muxData = sec;
      SRC_MIN:  muxData = min;
      SRC_HOUR: muxData = hour;
      SRC_WDAY: muxData = wday;
      SRC_MDAY: muxData = mday;
      SRC_MON:  muxData = mon + MONTH_BIAS;
      SRC_YEAR: muxData = year - YEAR_BIAS;
      default:  muxData = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secDiv <= '0;
      sec  <= presetSec;  min  <= presetMin;  hour <= presetHour;
      wday <= presetWday; mday <= presetMday; mon  <= presetMon;
      year <= presetYear;
    end else begin
      secDiv <= secTick ? '0 : secDiv + 1'b1;
      sec  <= nSec;  min  <= nMin;  hour <= nHour;
      wday <= nWday; mday <= nMday; mon  <= nMon;
      year <= nYear;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      perDiv      <= '0;
      periodicIrq <= 1'b0;
    end else begin
      perDiv      <= (perDiv == PER_LAST) ? '0 : perDiv + 1'b1;
      periodicIrq <= (perDiv == PER_LAST);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= 8'h00;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.load;
      if (strobe.load) rdData <= muxData;
    end
  end

endmodule

// File: rtl/rtc_index_port.sv
module rtc_index_port
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 50_000_000,
  parameter int PERIODIC_RATE = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       portSel,
  input  logic [7:0] wrData,
  input  logic [7:0] presetSec,
  input  logic [7:0] presetMin,
  input  logic [7:0] presetHour,
  input  logic [7:0] presetWday,
  input  logic [7:0] presetMday,
  input  logic [7:0] presetMon,
  input  logic [7:0] presetYear,
  output logic [7:0] rdData,
  output logic       rdValid,
  output logic       errPulse,
  output logic       periodicIrq
);

  ctl_strobe_t strobe;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .portSel(portSel),
    .wrData(wrData), .strobe(strobe), .errPulse(errPulse)
  );

  rtc_calendar #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .PERIODIC_RATE(PERIODIC_RATE)
  ) u_cal (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .presetSec(presetSec), .presetMin(presetMin), .presetHour(presetHour),
    .presetWday(presetWday), .presetMday(presetMday), .presetMon(presetMon),
    .presetYear(presetYear),
    .rdData(rdData), .rdValid(rdValid), .periodicIrq(periodicIrq)
  );

endmodule

// File: rtl/rtc_index_port_chk.sv
module rtc_index_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdEn,
  input logic       wrEn,
  input logic       portSel,
  input logic [7:0] rdData,
  input logic       rdValid,
  input logic       errPulse,
  input logic       periodicIrq
);

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn && portSel)); // R1

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R1

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !wrEn) |=> !errPulse); // R4

  AST_DATA_WR_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel) |=> errPulse); // R5

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    periodicIrq |=> !periodicIrq); // R10

endmodule

bind rtc_index_port rtc_index_port_chk u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .portSel(portSel),
  .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse),
  .periodicIrq(periodicIrq)
);

// File: tb/rtc_index_port_bench.sv
`timescale 1ns/1ps
module rtc_index_port_bench;

  localparam int TPS  = 64;
  localparam int RATE = 16;
  localparam int DIV  = TPS / RATE;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdEn = 1'b0, wrEn = 1'b0, portSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] pSec = 0, pMin = 0, pHour = 0, pWday = 0, pMday = 1, pMon = 0, pYear = 0;
  logic [7:0] rdData;
  logic rdValid, errPulse, periodicIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rtc_index_port #(.TICKS_PER_SEC(TPS), .PERIODIC_RATE(RATE)) u_rtc_index_port (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .portSel(portSel),
    .wrData(wrData), .presetSec(pSec), .presetMin(pMin), .presetHour(pHour),
    .presetWday(pWday), .presetMday(pMday), .presetMon(pMon), .presetYear(pYear),
    .rdData(rdData), .rdValid(rdValid), .errPulse(errPulse),
    .periodicIrq(periodicIrq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input int s, input int mi, input int h, input int wd,
                         input int md, input int mo, input int y);
    @(negedge clk);
    pSec = 8'(s); pMin = 8'(mi); pHour = 8'(h); pWday = 8'(wd);
    pMday = 8'(md); pMon = 8'(mo); pYear = 8'(y);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeIndex(input logic [7:0] idx);
    @(negedge clk);
    wrEn = 1'b1; portSel = 1'b0; wrData = idx;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readData(output logic [7:0] d, output logic v, output logic e);
    @(negedge clk);
    rdEn = 1'b1; portSel = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData; v = rdValid; e = errPulse;
  endtask

  task automatic expectReg(input string req, input logic [7:0] idx, input int exp);
    logic [7:0] d; logic v, e;
    writeIndex(idx);
    readData(d, v, e);
    check(req, d, exp);
    check(req, v, 1);
    check(req, e, 0);
  endtask

  task automatic expectDate(input string req, input int s, input int mi, input int h,
                            input int wd, input int md, input int mo, input int y);
    expectReg(req, 8'h00, s);
    expectReg(req, 8'h02, mi);
    expectReg(req, 8'h04, h);
    expectReg(req, 8'h06, wd);
    expectReg(req, 8'h07, md);
    expectReg(req, 8'h08, mo);
    expectReg(req, 8'h09, y);
  endtask

  task automatic waitSeconds(input int n);
    repeat (n * TPS + 4) @(negedge clk);
  endtask

  task automatic testReset();
    doReset(0, 0, 0, 0, 1, 0, 100);
    check("R1 reset rdData", rdData, 0);
    check("R1 reset rdValid", rdValid, 0);
    check("R1 reset errPulse", errPulse, 0);
    check("R1 reset periodicIrq", periodicIrq, 0);
  endtask

  task automatic testUip();
    doReset(0, 0, 0, 0, 1, 0, 100);
    expectReg("R2 first A", 8'h0A, 8'hA6);
    expectReg("R2 second A", 8'h0A, 8'h26);
    expectReg("R2 B no flip", 8'h0B, 8'h46);
    expectReg("R2 third A", 8'h0A, 8'hA6);
  endtask

  task automatic testConst();
    doReset(0, 0, 0, 0, 1, 0, 100);
    expectReg("R3 reg B", 8'h0B, 8'h46);
    expectReg("R3 reg C", 8'h0C, 8'h00);
  endtask

  task automatic testErrors();
    logic [7:0] d; logic v, e;
    doReset(5, 0, 0, 0, 1, 0, 100);
    writeIndex(8'h0D);
    readData(d, v, e);
    check("R4 reg D data", d, 0); check("R4 reg D valid", v, 1); check("R4 reg D err", e, 1);
    writeIndex(8'h33);
    readData(d, v, e);
    check("R4 unknown data", d, 0); check("R4 unknown err", e, 1);
    @(negedge clk);
    rdEn = 1'b1; portSel = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
    check("R4 index read err", errPulse, 1);
    check("R4 index read valid", rdValid, 0);
  endtask

  task automatic testDataWrite();
    doReset(0, 0, 0, 0, 1, 0, 100);
    writeIndex(8'h0B);
    @(negedge clk);
    wrEn = 1'b1; portSel = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0;
    check("R5 data write err", errPulse, 1);
    begin
      logic [7:0] d; logic v, e;
      readData(d, v, e);
      check("R5 index kept", d, 8'h46);
    end
  endtask

  task automatic testPreset();
    doReset(17, 42, 13, 2, 15, 6, 123);
    expectDate("R6 R7 preset fields", 17, 42, 13, 2, 15, 7, 71);
  endtask

  task automatic testTick();
    doReset(10, 5, 7, 3, 9, 2, 120);
    waitSeconds(3);
    expectReg("R8 seconds advance", 8'h00, 13);
    expectReg("R8 minute kept", 8'h02, 5);
    doReset(58, 59, 23, 6, 28, 1, 100);
    waitSeconds(2);
    expectDate("R8 R9 leap 2000 Feb 29", 0, 0, 0, 0, 29, 2, 48);
  endtask

  task automatic testMonths();
    doReset(59, 59, 23, 1, 28, 1, 101);
    waitSeconds(1);
    expectDate("R9 non-leap 2001 Mar 1", 0, 0, 0, 2, 1, 3, 49);
    doReset(59, 59, 23, 4, 28, 1, 200);
    waitSeconds(1);
    expectDate("R9 century 2100 Mar 1", 0, 0, 0, 5, 1, 3, 148);
    doReset(59, 59, 23, 2, 30, 3, 110);
    waitSeconds(1);
    expectDate("R9 Apr 30 to May 1", 0, 0, 0, 3, 1, 5, 58);
    doReset(59, 59, 23, 3, 31, 11, 99);
    waitSeconds(1);
    expectDate("R9 year rollover", 0, 0, 0, 4, 1, 1, 48);
  endtask

  task automatic testIrq();
    int highs = 0;
    int lastHigh = -1;
    int gapBad = 0;
    doReset(0, 0, 0, 0, 1, 0, 100);
    for (int i = 0; i < 10 * DIV; i++) begin
      @(negedge clk);
      if (periodicIrq) begin
        highs++;
        if (lastHigh >= 0 && (i - lastHigh) != DIV) gapBad++;
        lastHigh = i;
      end
    end
    check("R10 pulse count", highs, 10);
    check("R10 pulse spacing", gapBad, 0);
  endtask

  initial begin
    testReset();
    testUip();
    testConst();
    testErrors();
    testDataWrite();
    testPreset();
    testTick();
    testMonths();
    testIrq();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule